// File: doc/BRIEF.md
# Expansion Adapter Control Register

This block holds the 16-bit control word that the main processor uses to attach an add-on unit to its address map. The word carries three live bits. Bit 0 enables the adapter. Bit 1 is an active-low reset for the add-on's secondary processors. Bit 15 says which side owns the add-on's video resources. Each bit drives a port, so the rest of the chip sees the current state straight away.

The block also sits in the path of the cartridge I/O page. While the adapter is disabled, the page passes through: reads return cartridge data and write strobes reach the cartridge. While it is enabled, the cartridge registers are hidden. Reads return zero, and the lower-write strobe to the cartridge is held off. In both states a fixed four-byte identifier answers at four consecutive offsets of the page.

Top module: `exp_adapter_ctl`

## Requirements
- R1: After reset the control word reads 0x0000: adapterEn=0, secResetN=0, busOwnerSec=0, videoGrant=0.
- R2: A control write is accepted on the clock edge where ctrlWe=1. It is visible on ctrlRdata and the bit ports from the next cycle. Lane ctrlBe[0] writes bit 0 (enable) and bit 1 (active-low secondary reset). Lane ctrlBe[1] writes bit 15 (bus owner, 1 = secondary side). A lane whose enable is 0 leaves its bits unchanged.
- R3: Bits 14..2 of ctrlRdata always read 0, whatever was written.
- R4: While adapterEn=0, an I/O-page access at an offset outside the identifier returns cartRdData on ioRdData. A write there drives cartLowerWr=1.
- R5: The identifier answers in both adapter states. Offset ID_BASE+k (k = 0..3) returns byte k of ID_WORD, where byte 0 is ID_WORD[31:24] and byte 3 is ID_WORD[7:0].
- R6: While adapterEn=1, every I/O-page offset outside the identifier reads 0x00.
- R7: While adapterEn=1, cartLowerWr stays 0 for any access. cartSel follows ioSel for both reads and writes in either state.
- R8: videoGrant is 1 only when the adapter is enabled and bit 15 is 0.
- R9: The enable and reset bits are independent. Enabling the adapter with bit 1 = 0 gives adapterEn=1 with secResetN=0, and that state holds until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control word write request |
| ctrlBe | input | 2 | Byte-lane enables for the control write |
| ctrlWdata | input | 16 | Control write data |
| ctrlRdata | output | 16 | Control word read-back |
| ioSel | input | 1 | I/O page selected by the main bus |
| ioRead | input | 1 | I/O page read cycle |
| ioWrite | input | 1 | I/O page write cycle |
| ioAddr | input | IO_AW | Byte offset within the I/O page |
| cartRdData | input | 8 | Read data from cartridge hardware |
| ioRdData | output | 8 | Read data returned to the main bus |
| cartSel | output | 1 | I/O page strobe to the cartridge |
| cartLowerWr | output | 1 | Lower-write strobe to the cartridge |
| adapterEn | output | 1 | Adapter enabled |
| secResetN | output | 1 | Secondary-processor reset, active low |
| busOwnerSec | output | 1 | Video resources owned by the secondary side |
| videoGrant | output | 1 | Main processor may reach the video resources |

## Verification
If an internal bit holds the wrong value, the ports show it one cycle after the write: on ctrlRdata and on the matching output pin. If the enable bit is wrong, the I/O page shows it in the same cycle as the access. Cartridge data appears where zeros are expected, or a lower-write pulse escapes. The stimulus therefore checks both I/O directions, inside and outside the identifier window, in each adapter state. It also writes one byte lane at a time, so that a bit crossing between lanes shows up.

// File: rtl/exp_adapter_pkg.sv
package exp_adapter_pkg;
  localparam int CtrlW     = 16;
  localparam int EnBit     = 0;
  localparam int RstNBit   = 1;
  localparam int OwnerBit  = 15;
  localparam int IdBytes   = 4;
  localparam int IdIdxW    = $clog2(IdBytes);

  typedef struct packed {
    logic              loLaneWr;
    logic              hiLaneWr;
    logic              idHit;
    logic [IdIdxW-1:0] idIdx;
    logic              passCart;
  } ctrlStrobes_t;
endpackage

// File: rtl/exp_adapter_decode.sv
module exp_adapter_decode
  import exp_adapter_pkg::*;
#(
  parameter int IO_AW = 8,
  parameter logic [IO_AW-1:0] ID_BASE = 8'hEC
) (
  input  logic             ctrlWe,
  input  logic [1:0]       ctrlBe,
  input  logic             ioSel,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             enState,
  output ctrlStrobes_t     strobes
);
  logic [IO_AW-1:0] idOffset;

  always_comb begin
    idOffset          = ioAddr - ID_BASE;
    strobes.loLaneWr  = ctrlWe & ctrlBe[0];
    strobes.hiLaneWr  = ctrlWe & ctrlBe[1];
    strobes.idHit     = ioSel & (idOffset < IO_AW'(IdBytes));
    strobes.idIdx     = idOffset[IdIdxW-1:0];
    strobes.passCart  = ~enState;
  end
endmodule

// File: rtl/exp_adapter_datapath.sv
module exp_adapter_datapath
  import exp_adapter_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h5A17C3E8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CtrlW-1:0] ctrlWdata,
  input  logic             ioSel,
  input  logic             ioRead,
  input  logic             ioWrite,
  input  logic [7:0]       cartRdData,
  output logic [CtrlW-1:0] ctrlRdata,
  output logic [7:0]       ioRdData,
  output logic             cartSel,
  output logic             cartLowerWr,
  output logic             enQ,
  output logic             rstNQ,
  output logic             ownerQ
);
  logic [7:0] idBytes [IdBytes];

  genvar gi;
  generate
    for (gi = 0; gi < IdBytes; gi++) begin : g_id
      assign idBytes[gi] = ID_WORD[31-8*gi -: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      rstNQ  <= 1'b0;
      ownerQ <= 1'b0;
    end else begin
      if (strobes.loLaneWr) begin
        enQ   <= ctrlWdata[EnBit];
        rstNQ <= ctrlWdata[RstNBit];
      end
      if (strobes.hiLaneWr) ownerQ <= ctrlWdata[OwnerBit];
    end
  end

  always_comb begin
    ctrlRdata           = '0;
    ctrlRdata[EnBit]    = enQ;
    ctrlRdata[RstNBit]  = rstNQ;
    ctrlRdata[OwnerBit] = ownerQ;
    if (strobes.idHit)         ioRdData = idBytes[strobes.idIdx];
    else if (strobes.passCart) ioRdData = cartRdData;
    else                       ioRdData = 8'h00;
    cartSel     = ioSel & (ioRead | ioWrite);
    cartLowerWr = ioSel & ioWrite & strobes.passCart;
  end
endmodule

// File: rtl/exp_adapter_ctl.sv
module exp_adapter_ctl
  import exp_adapter_pkg::*;
#(
  parameter int IO_AW = 8,
  parameter logic [IO_AW-1:0] ID_BASE = 8'hEC,
  parameter logic [31:0] ID_WORD = 32'h5A17C3E8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [1:0]       ctrlBe,
  input  logic [15:0]      ctrlWdata,
  output logic [15:0]      ctrlRdata,
  input  logic             ioSel,
  input  logic             ioRead,
  input  logic             ioWrite,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic [7:0]       cartRdData,
  output logic [7:0]       ioRdData,
  output logic             cartSel,
  output logic             cartLowerWr,
  output logic             adapterEn,
  output logic             secResetN,
  output logic             busOwnerSec,
  output logic             videoGrant
);
  ctrlStrobes_t strobes;
  logic enQ, rstNQ, ownerQ;

  exp_adapter_decode #(.IO_AW(IO_AW), .ID_BASE(ID_BASE)) u_decode (
    .ctrlWe(ctrlWe), .ctrlBe(ctrlBe), .ioSel(ioSel), .ioAddr(ioAddr),
    .enState(enQ), .strobes(strobes)
  );

  exp_adapter_datapath #(.ID_WORD(ID_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctrlWdata(ctrlWdata),
    .ioSel(ioSel), .ioRead(ioRead), .ioWrite(ioWrite), .cartRdData(cartRdData),
    .ctrlRdata(ctrlRdata), .ioRdData(ioRdData), .cartSel(cartSel),
    .cartLowerWr(cartLowerWr), .enQ(enQ), .rstNQ(rstNQ), .ownerQ(ownerQ)
  );

  assign adapterEn   = enQ;
  assign secResetN   = rstNQ;
  assign busOwnerSec = ownerQ;
  assign videoGrant  = enQ & ~ownerQ;
endmodule

// File: rtl/exp_adapter_ctl_chk.sv
module exp_adapter_ctl_chk #(
  parameter int IO_AW = 8,
  parameter logic [IO_AW-1:0] ID_BASE = 8'hEC
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWe,
  input logic [1:0]       ctrlBe,
  input logic [15:0]      ctrlWdata,
  input logic [15:0]      ctrlRdata,
  input logic             ioSel,
  input logic             ioWrite,
  input logic [IO_AW-1:0] ioAddr,
  input logic [7:0]       ioRdData,
  input logic             cartLowerWr,
  input logic             adapterEn,
  input logic             secResetN,
  input logic             busOwnerSec,
  input logic             videoGrant
);
  logic inIdWindow;
  assign inIdWindow = (ioAddr >= ID_BASE) && (ioAddr <= ID_BASE + IO_AW'(3));

  p_lo_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlBe[0] |=> adapterEn == $past(ctrlWdata[0]) && secResetN == $past(ctrlWdata[1]));
  p_hi_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlBe[1] |=> busOwnerSec == $past(ctrlWdata[15]));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWe |=> $stable(ctrlRdata));
  p_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[14:2] == 13'd0);
  p_zero_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    adapterEn && ioSel && !inIdWindow |-> ioRdData == 8'h00);
  p_no_lwr_r7: assert property (@(posedge clk) disable iff (!rstN)
    adapterEn |-> !cartLowerWr);
  p_lwr_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    !adapterEn && ioSel && ioWrite |-> cartLowerWr);
  p_video_r8: assert property (@(posedge clk) disable iff (!rstN)
    busOwnerSec |-> !videoGrant);
endmodule

bind exp_adapter_ctl exp_adapter_ctl_chk #(.IO_AW(IO_AW), .ID_BASE(ID_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlBe(ctrlBe), .ctrlWdata(ctrlWdata),
  .ctrlRdata(ctrlRdata), .ioSel(ioSel), .ioWrite(ioWrite), .ioAddr(ioAddr),
  .ioRdData(ioRdData), .cartLowerWr(cartLowerWr), .adapterEn(adapterEn),
  .secResetN(secResetN), .busOwnerSec(busOwnerSec), .videoGrant(videoGrant)
);

// File: tb/tb_exp_adapter_ctl.sv
`timescale 1ns/1ps
module tb_exp_adapter_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [1:0]  ctrlBe = 2'b00;
  logic [15:0] ctrlWdata = '0;
  logic [15:0] ctrlRdata;
  logic        ioSel = 1'b0, ioRead = 1'b0, ioWrite = 1'b0;
  logic [7:0]  ioAddr = '0, cartRdData = '0, ioRdData;
  logic        cartSel, cartLowerWr, adapterEn, secResetN, busOwnerSec, videoGrant;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  exp_adapter_ctl dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlBe(ctrlBe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .ioSel(ioSel), .ioRead(ioRead), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .cartRdData(cartRdData), .ioRdData(ioRdData), .cartSel(cartSel),
    .cartLowerWr(cartLowerWr), .adapterEn(adapterEn), .secResetN(secResetN),
    .busOwnerSec(busOwnerSec), .videoGrant(videoGrant)
  );

  // {en, wr, addr, cart, expRd, expLwr}; identifier 5A 17 C3 E8 at EC..EF
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h01, 8'hA5, 8'hA5, 1'b0},  // R4
    {1'b0, 1'b1, 8'h01, 8'h00, 8'h00, 1'b1},  // R4
    {1'b0, 1'b0, 8'hEC, 8'h11, 8'h5A, 1'b0},  // R5
    {1'b0, 1'b0, 8'hEF, 8'h11, 8'hE8, 1'b0},  // R5
    {1'b0, 1'b0, 8'hF0, 8'h3C, 8'h3C, 1'b0},  // R4
    {1'b1, 1'b0, 8'h01, 8'hA5, 8'h00, 1'b0},  // R6
    {1'b1, 1'b0, 8'hED, 8'hFF, 8'h17, 1'b0},  // R5
    {1'b1, 1'b0, 8'hEE, 8'hFF, 8'hC3, 1'b0},  // R5
    {1'b1, 1'b1, 8'h01, 8'h5A, 8'h00, 1'b0},  // R7
    {1'b1, 1'b0, 8'hEB, 8'h77, 8'h00, 1'b0},  // R6
    {1'b1, 1'b1, 8'hEC, 8'h99, 8'h5A, 1'b0}   // R7
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlBe = be; ctrlWdata = d;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlBe = 2'b00;
    #1;
  endtask

  function automatic logic [15:0] portWord();
    return {busOwnerSec, 11'd0, videoGrant, 1'b0, secResetN, adapterEn};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 ctrl", ctrlRdata, 16'h0000);
    check("R1 pins", portWord(), 16'h0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      if (adapterEn !== v[26]) writeCtrl(2'b01, {14'd0, 1'b0, v[26]});
      @(negedge clk);
      ioSel = 1'b1; ioWrite = v[25]; ioRead = ~v[25];
      ioAddr = v[24:17]; cartRdData = v[16:9];
      #1;
      check(v[26] ? "R5/R6 rd" : "R4/R5 rd", {8'h00, ioRdData}, {8'h00, v[8:1]});
      check(v[26] ? "R7 lwr" : "R4 lwr", {15'd0, cartLowerWr}, {15'd0, v[0]});
      check("R7 sel", {15'd0, cartSel}, 16'h0001);
      @(negedge clk);
      ioSel = 1'b0; ioWrite = 1'b0; ioRead = 1'b0;
    end

    // directed lane and field tests
    writeCtrl(2'b11, 16'h0000);
    check("R1 cleared", ctrlRdata, 16'h0000);
    writeCtrl(2'b01, 16'h0003);
    check("R2 low lane", ctrlRdata, 16'h0003);
    check("R8 grant", {15'd0, videoGrant}, 16'h0001);
    writeCtrl(2'b10, 16'h80FC);
    check("R2 high lane", ctrlRdata, 16'h8003);
    check("R8 owner blocks", {15'd0, videoGrant}, 16'h0000);
    writeCtrl(2'b11, 16'hFFFF);
    check("R3 reserved", ctrlRdata, 16'h8003);
    writeCtrl(2'b00, 16'h0000);
    check("R2 no lane", ctrlRdata, 16'h8003);
    writeCtrl(2'b11, 16'h0001);
    check("R9 en w/ reset", {14'd0, secResetN, adapterEn}, 16'h0001);
    check("R8 grant back", {15'd0, videoGrant}, 16'h0001);
    repeat (4) @(negedge clk);
    check("R9 held", ctrlRdata, 16'h0001);
    writeCtrl(2'b01, 16'h0002);
    check("R9 reset released alone", {14'd0, secResetN, adapterEn}, 16'h0002);
    check("R8 disabled", {15'd0, videoGrant}, 16'h0000);

    // mid-run reset
    writeCtrl(2'b11, 16'h8003);
    @(negedge clk); rstN = 1'b0; #1;
    check("R1 async reset", ctrlRdata, 16'h0000);
    @(negedge clk); rstN = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule